// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses where instruction fetch goes next in a 32-bit fetch stage whose instructions are word-aligned. It holds the current program counter in a register. From the instruction word it forms four candidate addresses and picks one. The candidates are the sequential address (PC plus 4), a PC-relative branch target, a pseudo-direct jump target, and a target read from a register. The ALU compare result, passed in as a single taken bit, decides conditional branches. The register value for jump-register comes from the register file.

The next address is a combinational function of the held PC and the current inputs. It is valid in the same cycle. It is loaded into the PC register on a clock edge when the step input is high. For the jump-and-link opcode, the block also presents a link write: the return address PC plus 4 and destination register 31. The register file can take this write without decoding anything itself.

Top module: `npc_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, `pc` equals the parameter `RESET_VEC` (default 0x0040_0000) until the first step.
- R2: An instruction whose opcode (bits 31:26) is none of 0x00, 0x02, 0x03, 0x04, 0x05 gives `next_pc` = `pc` + 4, whatever the value of `taken`.
- R3: Opcode 0x04 (branch if equal) or 0x05 (branch if not equal) with `taken` high gives `next_pc` = `pc` + 4 + (sign-extended bits 15:0) × 4.
- R4: Opcode 0x04 or 0x05 with `taken` low gives `next_pc` = `pc` + 4.
- R5: Negative branch offsets, including the most negative one (0x8000), give targets below `pc` + 4.
- R6: Opcode 0x02 (jump) gives `next_pc` = {`pc`[31:28], bits 25:0, 2'b00}.
- R7: Opcode 0x03 (jump and link) gives the same target as R6. It also sets `link_we` high, `link_addr` = `pc` + 4 and `link_reg` = 31.
- R8: Opcode 0x00 with function field (bits 5:0) 0x08 gives `next_pc` = `reg_target`.
- R9: Opcode 0x00 with any other function field gives `next_pc` = `pc` + 4.
- R10: When `step` is high at a rising clock edge, `pc` takes that cycle's `next_pc`. When `step` is low, `pc` is unchanged.
- R11: `link_we` is low for every opcode other than 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Load `next_pc` into the PC register at this edge |
| instr | input | 32 | Instruction word fetched at `pc` |
| taken | input | 1 | Branch condition from the ALU compare |
| reg_target | input | 32 | Register value for jump-register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Selected next fetch address |
| link_we | output | 1 | Link write request (jump and link) |
| link_reg | output | 5 | Destination register of the link write |
| link_addr | output | 32 | Return address for the link write |

## Verification
`next_pc` and the three link outputs depend combinationally on the held PC and the inputs of the same cycle. They are due as soon as the inputs settle, with zero cycles of latency. `pc` changes one rising edge after a cycle in which `step` was high. The driver task applies each stimulus on a falling edge and pushes its expected item into a queue. The monitor compares the item 2 ns later, inside the same low phase, before the next rising edge. The expected `pc` in every item comes from a model that advances only across a stepped edge, so every check also tests the one-edge update and the hold case.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned OP_W      = 6;
    localparam int unsigned IMM_W     = 16;
    localparam int unsigned JFIELD_W  = 26;
    localparam int unsigned REGIDX_W  = 5;
    localparam int unsigned REGION_W  = XLEN - JFIELD_W - 2;
    localparam int unsigned SEXT_W    = XLEN - IMM_W - 2;

    localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP    = 6'h02;
    localparam logic [OP_W-1:0] OP_JLINK   = 6'h03;
    localparam logic [OP_W-1:0] OP_BREQ    = 6'h04;
    localparam logic [OP_W-1:0] OP_BRNE    = 6'h05;
    localparam logic [OP_W-1:0] FN_JREG    = 6'h08;

    typedef enum logic [1:0] {
        PICK_SEQ    = 2'd0,
        PICK_BRANCH = 2'd1,
        PICK_JUMP   = 2'd2,
        PICK_REG    = 2'd3
    } pick_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } fetch_state_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic            taken,
    output pick_e           pick,
    output logic            link
);
    logic [OP_W-1:0] opcode;
    logic [OP_W-1:0] funct;

    assign opcode = instr[XLEN-1 -: OP_W];
    assign funct  = instr[OP_W-1:0];

    always_comb begin
        pick = PICK_SEQ;
        link = 1'b0;
        unique case (opcode)
            OP_SPECIAL: if (funct == FN_JREG) pick = PICK_REG;
            OP_JUMP:    pick = PICK_JUMP;
            OP_JLINK: begin
                pick = PICK_JUMP;
                link = 1'b1;
            end
            OP_BREQ, OP_BRNE: if (taken) pick = PICK_BRANCH;
            default:    pick = PICK_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] seq_addr,
    output logic [XLEN-1:0] branch_addr,
    output logic [XLEN-1:0] jump_addr
);
    logic [IMM_W-1:0] offset;
    logic [XLEN-1:0]  offset_bytes;

    assign offset       = instr[IMM_W-1:0];
    assign offset_bytes = {{SEXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    assign seq_addr     = pc + XLEN'(4);
    assign branch_addr  = seq_addr + offset_bytes;
    assign jump_addr    = {pc[XLEN-1 -: REGION_W], instr[JFIELD_W-1:0], 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  pick_e           pick,
    input  logic [XLEN-1:0] seq_addr,
    input  logic [XLEN-1:0] branch_addr,
    input  logic [XLEN-1:0] jump_addr,
    input  logic [XLEN-1:0] reg_addr,
    output logic [XLEN-1:0] chosen
);
    always_comb begin
        unique case (pick)
            PICK_BRANCH: chosen = branch_addr;
            PICK_JUMP:   chosen = jump_addr;
            PICK_REG:    chosen = reg_addr;
            default:     chosen = seq_addr;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000,
    parameter logic [4:0]  LINK_REG  = 5'd31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic [31:0] instr,
    input  logic        taken,
    input  logic [31:0] reg_target,
    output logic [31:0] pc,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [4:0]  link_reg,
    output logic [31:0] link_addr
);
    fetch_state_t state_d, state_q;
    pick_e        pick;
    logic         link;
    logic [XLEN-1:0] seq_addr, branch_addr, jump_addr, chosen;

    npc_decode i_decode (
        .instr (instr),
        .taken (taken),
        .pick  (pick),
        .link  (link)
    );

    npc_targets i_targets (
        .pc          (state_q.pc),
        .instr       (instr),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr)
    );

    npc_select i_select (
        .pick        (pick),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr),
        .reg_addr    (reg_target),
        .chosen      (chosen)
    );

    always_comb begin
        state_d = state_q;
        if (step) state_d.pc = chosen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q.pc <= RESET_VEC;
        else        state_q    <= state_d;
    end

    assign pc        = state_q.pc;
    assign next_pc   = chosen;
    assign link_we   = link;
    assign link_reg  = link ? LINK_REG : '0;
    assign link_addr = seq_addr;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc));
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (pc == $past(next_pc)));
    p_link_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_addr == pc + 32'd4 && link_reg == LINK_REG));
    p_link_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (instr[31:26] == OP_JLINK));
    p_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((instr[31:26] == OP_BREQ || instr[31:26] == OP_BRNE) && !taken)
        |-> (next_pc == pc + 32'd4));
    p_jreg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OP_SPECIAL && instr[5:0] == FN_JREG)
        |-> (next_pc == reg_target));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    localparam logic [31:0] RV = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [31:0] instr = '0;
    logic        taken = 1'b0;
    logic [31:0] reg_target = '0;
    logic [31:0] pc, next_pc, link_addr;
    logic        link_we;
    logic [4:0]  link_reg;

    typedef struct {
        logic [31:0] exp_pc;
        logic [31:0] exp_next;
        logic        exp_we;
        logic [31:0] exp_link;
        string       tag;
    } item_t;

    item_t       sb[$];
    event        applied;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] model_pc = RV;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) i_npc_unit (
        .clk(clk), .rst_n(rst_n), .step(step), .instr(instr), .taken(taken),
        .reg_target(reg_target), .pc(pc), .next_pc(next_pc), .link_we(link_we),
        .link_reg(link_reg), .link_addr(link_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] w,
                                               input logic t, input logic [31:0] r);
        logic [5:0] op = w[31:26];
        if (op == 6'h02 || op == 6'h03) return {p[31:28], w[25:0], 2'b00};
        if ((op == 6'h04 || op == 6'h05) && t)
            return p + 32'd4 + ({{16{w[15]}}, w[15:0]} <<< 2);
        if (op == 6'h00 && w[5:0] == 6'h08) return r;
        return p + 32'd4;
    endfunction

    task automatic apply(input logic [31:0] w, input logic t, input logic [31:0] r,
                         input logic s, input string tag);
        item_t it;
        @(negedge clk);
        instr = w; taken = t; reg_target = r; step = s;
        it.exp_pc   = model_pc;
        it.exp_next = model_next(model_pc, w, t, r);
        it.exp_we   = (w[31:26] == 6'h03);
        it.exp_link = model_pc + 32'd4;
        it.tag      = tag;
        sb.push_back(it);
        -> applied;
        @(posedge clk);
        if (s) model_pc = it.exp_next;
    endtask

    initial begin : monitor
        forever begin
            item_t it;
            @(applied);
            #2;
            it = sb.pop_front();
            check({it.tag, " pc (R1/R10)"}, pc, it.exp_pc);
            check({it.tag, " next_pc"}, next_pc, it.exp_next);
            check({it.tag, " link_we (R7/R11)"}, {31'd0, link_we}, {31'd0, it.exp_we});
            if (it.exp_we) begin
                check({it.tag, " link_addr R7"}, link_addr, it.exp_link);
                check({it.tag, " link_reg R7"}, {27'd0, link_reg}, 32'd31);
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : driver
        #12;
        check("R1 pc during reset", pc, RV);
        @(negedge clk);
        rst_n = 1'b1;
        apply(32'h0000_0000, 1'b1, 32'h0, 1'b0, "R9 op0 funct0 r1_reset");
        apply(32'h2008_0005, 1'b1, 32'h0, 1'b1, "R2 other op, taken ignored");
        apply(32'h1085_0003, 1'b1, 32'h0, 1'b1, "R3 beq taken fwd");
        apply(32'h1485_0005, 1'b0, 32'h0, 1'b0, "R4 bne not taken");
        apply(32'h1085_0007, 1'b0, 32'h0, 1'b0, "R4 beq not taken");
        apply(32'h1485_FFFE, 1'b1, 32'h0, 1'b1, "R5 bne taken back");
        apply(32'h1085_8000, 1'b1, 32'h0, 1'b0, "R5 most negative offset");
        apply(32'h0000_0021, 1'b0, 32'hDEAD_BEE0, 1'b0, "R9 op0 other funct");
        apply(32'h0120_0008, 1'b0, 32'hA000_0100, 1'b1, "R8 jr");
        apply(32'h0BFF_FFFF, 1'b0, 32'h0, 1'b0, "R6 j max field");
        apply(32'h0C00_0040, 1'b0, 32'h0, 1'b0, "R7 jal hold R10");
        apply(32'h0C00_0080, 1'b0, 32'h0, 1'b1, "R7 jal step");
        apply(32'h1800_0010, 1'b1, 32'h0, 1'b0, "R2 blez-like op ignores taken R11");
        apply(32'h0800_0000, 1'b0, 32'h0, 1'b1, "R6 j zero field");
        apply(32'h0000_0000, 1'b0, 32'h0, 1'b0, "R10 after jump");
        #20;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule